// File: doc/BRIEF.md
# UART Receive Character Queue with Sticky Error Status

This block sits behind the deserializer of one UART receive channel. Every received character arrives on a push strobe together with three per-character flags (break, framing error, parity error). It is stored in a 256-entry first-in first-out queue. A host takes characters out with a pop strobe. The popped character and its flags appear on registered outputs one clock later.

Beside the queue the block keeps a four-bit sticky error status: break, framing, parity and overrun. Overrun is raised when a character arrives while the queue is full. The other three bits collect the per-character flags. By default a flag is folded into the status when its character is popped, so the status says that something already read was bad. A mode command moves the folding to the moment the character is pushed. The host then learns of a bad character up to a full queue earlier, but can no longer tell from the status which character it was.

A 5-bit command code drives the block. One code flushes the receive side, one clears the error status and one selects push-time folding. Every other code, including zero, leaves the block untouched.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: Characters leave in the order they were pushed, up to 256 stored at once. A pop accepted at a clock edge places the character on `rd_data` and its flags on `rd_err` after that same edge.
- R2: A push while `fifo_level` is 256 is discarded, even when a pop is made in the same cycle. It sets `err_status[0]` (overrun) after that edge, and the stored characters and the level are not changed.
- R3: A pop while the queue is empty leaves `rd_data`, `rd_err` and `fifo_level` unchanged.
- R4: Command code 5'h02 empties the queue, clears `err_status` and sets `rd_data` and `rd_err` to zero after that edge. A push or pop in the same cycle is ignored. The folding mode is kept.
- R5: Command code 5'h04 clears `err_status` and does not touch the queue. A flag folded in the same cycle is kept in the new status.
- R6: `err_status` bit order is {break, framing, parity, overrun} (bits 3..0), and the `rx_err`/`rd_err` order is {break, framing, parity} (bits 2..0). In the default mode a flagged push does not change `err_status`. Popping that character ORs its flags into bits 3..1 after the pop edge.
- R7: After command code 5'h0D, a flagged push ORs its flags into bits 3..1 after the push edge, and popping a character folds nothing.
- R8: Status bits are sticky. Once set, a bit stays set until command 5'h02, command 5'h04 or hardware reset.
- R9: All command codes other than 5'h02, 5'h04 and 5'h0D, including 5'h00, change neither the status nor the queue contents or level.
- R10: Hardware reset (`rst_n` low) empties the queue, clears the status and the read outputs, and restores pop-time folding.
- R11: `fifo_level` always equals the number of stored characters. `fifo_empty` is high at level 0 and `fifo_full` is high at level 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Push strobe for one received character |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Per-character flags {break, framing, parity} |
| rd_pop | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Last popped character |
| rd_err | output | 3 | Flags of the last popped character |
| cmd_code | input | 5 | Command code, 0 for no operation |
| err_status | output | 4 | Sticky status {break, framing, parity, overrun} |
| fifo_level | output | 9 | Number of stored characters |
| fifo_empty | output | 1 | Queue holds no character |
| fifo_full | output | 1 | Queue holds 256 characters |

## Verification
The assertions assume that every input is stable and known at each rising clock edge, and that `cmd_code` holds a command only for the cycle in which it is meant to act. The properties for the clear and overrun paths expect that no unrelated push or pop makes the same status bit rise in that cycle. The stimulus drives every input on the falling edge and returns it to zero after one cycle. When the bench wants two events in one cycle, as with a pop beside an error clear or a push beside a flush, it applies them together on purpose, and the properties guard those cases by their antecedents.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int ERR_W  = 3;
  localparam int STAT_W = 4;

  typedef enum logic [4:0] {
    RXQ_NOP       = 5'h00,
    RXQ_RX_RESET  = 5'h02,
    RXQ_ERR_CLEAR = 5'h04,
    RXQ_EARLY_ACC = 5'h0D
  } rxq_cmd_e;

  typedef enum logic {
    FOLD_ON_READ  = 1'b0,
    FOLD_ON_WRITE = 1'b1
  } fold_mode_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } char_err_t;

  // New sticky status: optional clear first, then OR in the new events.
  function automatic logic [STAT_W-1:0] fold_status(
    input logic [STAT_W-1:0] cur,
    input logic              clr,
    input char_err_t         flags,
    input logic              ovr
  );
    logic [STAT_W-1:0] base;
    base = clr ? '0 : cur;
    return base | {flags.brk, flags.frm, flags.par, ovr};
  endfunction

  // Flags to fold this cycle, chosen by the mode.
  function automatic char_err_t pick_flags(
    input fold_mode_e mode,
    input logic       wr_acc,
    input char_err_t  wr_err,
    input logic       rd_acc,
    input char_err_t  rd_err
  );
    if (mode == FOLD_ON_WRITE) return wr_acc ? wr_err : '0;
    return rd_acc ? rd_err : '0;
  endfunction

endpackage

// File: rtl/rxq_cmd_dec.sv
module rxq_cmd_dec
  import uart_rxq_pkg::*;
(
  input  logic [4:0] cmd_code,
  output logic       flush,
  output logic       err_clr,
  output logic       early_set
);
  always_comb begin
    flush     = (cmd_code == RXQ_RX_RESET);
    err_clr   = (cmd_code == RXQ_ERR_CLEAR);
    early_set = (cmd_code == RXQ_EARLY_ACC);
  end
endmodule

// File: rtl/rxq_ptr_ctl.sv
module rxq_ptr_ctl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          ovr_evt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);
  assign push_acc = push_req && !full && !flush;
  assign ovr_evt  = push_req && full && !flush;
  assign pop_acc  = pop_req && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_inc(rd_ptr);
      level <= level + CW'(push_acc) - CW'(pop_acc);
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] head_word,
  output logic [WIDTH-1:0] out_word
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  assign head_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_word <= '0;
    else if (flush) out_word <= '0;
    else if (rd_en) out_word <= head_word;
  end
endmodule

// File: rtl/rxq_err_acc.sv
module rxq_err_acc
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              err_clr,
  input  logic              early_set,
  input  logic              wr_acc,
  input  char_err_t         wr_err,
  input  logic              rd_acc,
  input  char_err_t         rd_err,
  input  logic              ovr_evt,
  output logic [STAT_W-1:0] status,
  output logic              early_mode
);
  fold_mode_e mode;
  char_err_t  sel;

  assign sel        = pick_flags(mode, wr_acc, wr_err, rd_acc, rd_err);
  assign early_mode = (mode == FOLD_ON_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode <= FOLD_ON_READ;
    else if (early_set) mode <= FOLD_ON_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= '0;
    else if (flush) status <= '0;
    else            status <= fold_status(status, err_clr, sel, ovr_evt);
  end
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_push,
  input  logic [DATA_W-1:0]      rx_data,
  input  logic [ERR_W-1:0]       rx_err,
  input  logic                   rd_pop,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ERR_W-1:0]       rd_err,
  input  logic [4:0]             cmd_code,
  output logic [STAT_W-1:0]      err_status,
  output logic [$clog2(DEPTH):0] fifo_level,
  output logic                   fifo_full,
  output logic                   fifo_empty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int WORD_W = DATA_W + ERR_W;

  // Named internal events, used by the bound checker.
  logic          flush, err_clr, early_set;
  logic          push_acc, pop_acc, ovr_evt;
  logic          early_mode;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [WORD_W-1:0] head_word, out_word;

  rxq_cmd_dec u_dec (
    .cmd_code (cmd_code),
    .flush    (flush),
    .err_clr  (err_clr),
    .early_set(early_set)
  );

  rxq_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push_req(rx_push),
    .pop_req (rd_pop),
    .push_acc(push_acc),
    .pop_acc (pop_acc),
    .ovr_evt (ovr_evt),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (push_acc),
    .wr_addr  (wr_ptr),
    .wr_word  ({rx_err, rx_data}),
    .rd_en    (pop_acc),
    .rd_addr  (rd_ptr),
    .head_word(head_word),
    .out_word (out_word)
  );

  rxq_err_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .err_clr   (err_clr),
    .early_set (early_set),
    .wr_acc    (push_acc),
    .wr_err    (char_err_t'(rx_err)),
    .rd_acc    (pop_acc),
    .rd_err    (char_err_t'(head_word[WORD_W-1 -: ERR_W])),
    .ovr_evt   (ovr_evt),
    .status    (err_status),
    .early_mode(early_mode)
  );

  assign rd_data = out_word[DATA_W-1:0];
  assign rd_err  = out_word[WORD_W-1 -: ERR_W];
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rx_push,
  input logic [2:0]             rx_err,
  input logic                   rd_pop,
  input logic [DATA_W-1:0]      rd_data,
  input logic [2:0]             rd_err,
  input logic [3:0]             err_status,
  input logic [$clog2(DEPTH):0] fifo_level,
  input logic                   fifo_full,
  input logic                   fifo_empty,
  input logic                   push_acc,
  input logic                   pop_acc,
  input logic                   flush,
  input logic                   err_clr,
  input logic                   early_mode
);
  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= DEPTH);

  // R11
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(fifo_level) ==
      int'($past(fifo_level)) + int'($past(push_acc)) - int'($past(pop_acc)));

  // R2
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && fifo_full && !flush) |=> err_status[0]);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && fifo_full && !rd_pop && !flush) |=> fifo_full);

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_empty && !flush) |=> ($stable(rd_data) && $stable(rd_err)));

  // R4
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_empty && err_status == 4'b0 && rd_data == '0));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_push && !rd_pop) |=> err_status == 4'b0);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !err_clr) |=>
      ((err_status & $past(err_status)) == $past(err_status)));

  // R7
  early_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early_mode && push_acc && !flush) |=>
      ((err_status[3:1] & $past(rx_err)) == $past(rx_err)));

  // R6
  read_nofold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_mode && !pop_acc) |=>
      ((err_status[3:1] & ~$past(err_status[3:1])) == 3'b0));
endmodule

bind uart_rx_err_fifo rxq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_push   (rx_push),
  .rx_err    (rx_err),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .rd_err    (rd_err),
  .err_status(err_status),
  .fifo_level(fifo_level),
  .fifo_full (fifo_full),
  .fifo_empty(fifo_empty),
  .push_acc  (push_acc),
  .pop_acc   (pop_acc),
  .flush     (flush),
  .err_clr   (err_clr),
  .early_mode(early_mode)
);

// File: tb/test_uart_rx_err_fifo.sv
module test_uart_rx_err_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic [2:0] rx_err = '0;
  logic       rd_pop = 1'b0;
  logic [4:0] cmd_code = '0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [3:0] err_status;
  logic [8:0] fifo_level;
  logic       fifo_full, fifo_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_err_fifo i_uart_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
    .rx_err(rx_err), .rd_pop(rd_pop), .rd_data(rd_data), .rd_err(rd_err),
    .cmd_code(cmd_code), .err_status(err_status), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic drive(input logic pv, input logic [7:0] pd, input logic [2:0] pe,
                       input logic pp, input logic [4:0] c);
    rx_push = pv; rx_data = pd; rx_err = pe; rd_pop = pp; cmd_code = c;
    @(negedge clk);
    rx_push = 1'b0; rx_data = '0; rx_err = '0; rd_pop = 1'b0; cmd_code = '0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    drive(1'b1, d, e, 1'b0, 5'h00);
  endtask

  task automatic pop();
    drive(1'b0, 8'h00, 3'b000, 1'b1, 5'h00);
  endtask

  task automatic cmd(input logic [4:0] c);
    drive(1'b0, 8'h00, 3'b000, 1'b0, c);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", "level after reset", 32'(fifo_level), 0);
    check("R10", "status after reset", 32'(err_status), 0);
    check("R10", "rd_data after reset", 32'(rd_data), 0);
    check("R11", "empty after reset", 32'(fifo_empty), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i), 3'b000);
    check("R11", "level after 5 pushes", 32'(fifo_level), 5);
    check("R11", "not empty", 32'(fifo_empty), 0);
    for (int i = 0; i < 5; i++) begin
      pop();
      check("R1", "pop order", 32'(rd_data), 32'(8'h40 + i));
    end
    check("R11", "empty after drain", 32'(fifo_empty), 1);
  endtask

  task automatic t_read_fold();
    push(8'h81, 3'b100);
    check("R6", "flagged push not folded", 32'(err_status), 0);
    pop();
    check("R6", "break folded on pop", 32'(err_status), 32'(4'b1000));
    check("R6", "rd_err of popped char", 32'(rd_err), 32'(3'b100));
    check("R1", "rd_data of popped char", 32'(rd_data), 32'h81);
    push(8'h82, 3'b001);
    pop();
    check("R8", "parity accumulates with break", 32'(err_status), 32'(4'b1010));
    push(8'h83, 3'b010);
    drive(1'b0, 8'h00, 3'b000, 1'b1, 5'h04);
    check("R5", "clear keeps same-cycle fold", 32'(err_status), 32'(4'b0100));
    cmd(5'h04);
    check("R5", "clear empties status", 32'(err_status), 0);
  endtask

  task automatic t_empty_pop();
    pop();
    check("R3", "rd_data unchanged", 32'(rd_data), 32'h83);
    check("R3", "rd_err unchanged", 32'(rd_err), 32'(3'b010));
    check("R3", "level stays 0", 32'(fifo_level), 0);
  endtask

  task automatic t_full();
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) push(8'(i), 3'b000);
    check("R11", "level at capacity", 32'(fifo_level), DEPTH);
    check("R11", "full flag", 32'(fifo_full), 1);
    check("R2", "no overrun yet", 32'(err_status), 0);
    drive(1'b1, 8'hAA, 3'b100, 1'b1, 5'h00);
    check("R2", "overrun on push with pop while full", 32'(err_status), 32'(4'b0001));
    check("R2", "level after discarded push", 32'(fifo_level), DEPTH - 1);
    check("R2", "popped head", 32'(rd_data), 0);
    push(8'hAB, 3'b000);
    check("R2", "refill to full", 32'(fifo_level), DEPTH);
    push(8'hAC, 3'b000);
    check("R2", "level held when full", 32'(fifo_level), DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      pop();
      if (rd_data !== 8'(i)) bad++;
    end
    pop();
    check("R2", "stored data after overrun", 32'(bad), 0);
    check("R2", "last char is accepted one", 32'(rd_data), 32'hAB);
    check("R8", "overrun sticky", 32'(err_status), 32'(4'b0001));
    cmd(5'h04);
  endtask

  task automatic t_nop();
    logic [4:0] codes [6] = '{5'h00, 5'h01, 5'h03, 5'h05, 5'h0C, 5'h1F};
    push(8'h77, 3'b100);
    pop();
    push(8'h5A, 3'b001);
    for (int k = 0; k < 6; k++) begin
      cmd(codes[k]);
      check("R9", "status unchanged by code", 32'(err_status), 32'(4'b1000));
      check("R9", "level unchanged by code", 32'(fifo_level), 1);
    end
    pop();
    check("R9", "stored char survives codes", 32'(rd_data), 32'h5A);
    check("R6", "parity folded after codes", 32'(err_status), 32'(4'b1010));
  endtask

  task automatic t_flush();
    push(8'h31, 3'b001);
    push(8'h32, 3'b000);
    push(8'h33, 3'b000);
    drive(1'b1, 8'h34, 3'b100, 1'b1, 5'h02);
    check("R4", "level after flush", 32'(fifo_level), 0);
    check("R4", "status after flush", 32'(err_status), 0);
    check("R4", "rd_data after flush", 32'(rd_data), 0);
    pop();
    check("R4", "nothing left after flush", 32'(rd_data), 0);
  endtask

  task automatic t_early();
    cmd(5'h0D);
    push(8'h11, 3'b010);
    check("R7", "framing folded on push", 32'(err_status), 32'(4'b0100));
    push(8'h22, 3'b001);
    check("R7", "parity folded on push", 32'(err_status), 32'(4'b0110));
    cmd(5'h04);
    pop();
    check("R7", "no fold on pop", 32'(err_status), 0);
    check("R7", "rd_err still per char", 32'(rd_err), 32'(3'b010));
    pop();
    check("R1", "second char", 32'(rd_data), 32'h22);
    cmd(5'h02);
    push(8'h44, 3'b100);
    check("R4", "mode kept across flush", 32'(err_status), 32'(4'b1000));
    hw_reset();
    check("R10", "level after hw reset", 32'(fifo_level), 0);
    check("R10", "status after hw reset", 32'(err_status), 0);
    push(8'h55, 3'b100);
    check("R10", "read mode restored", 32'(err_status), 0);
    pop();
    check("R10", "fold on pop again", 32'(err_status), 32'(4'b1000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_read_fold();
    t_empty_pop();
    t_full();
    t_nop();
    t_flush();
    t_early();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule